// File: doc/BRIEF.md
# Postfix Expression Evaluator

This block evaluates integer arithmetic expressions that arrive in postfix (reverse Polish) order. Tokens come in one at a time over a valid/ready handshake. Each token carries a kind tag and is one of three things: an operand, an operator, or an end-of-expression marker.

- An operand is pushed onto an internal last-in-first-out stack.
- An operator starts a sequence run by the control state machine. The sequence pops the right-hand value, pops the left-hand value, puts both through combinational arithmetic, and pushes the result.
- The end marker presents the top entry as the result, flags expressions that did not reduce to exactly one value, and empties the stack for the next expression.

Addition, subtraction and multiplication are supported, all modulo 2^WIDTH. Pushing onto a full stack is refused. An operator that finds fewer than two entries is refused. Each of these refusals is recorded in a sticky error flag that only reset clears. The stack is 8 entries of 16 bits by default.

Top module: `rpn_eval`

## Requirements
- R1: A token with kind 2'b00 is an operand. When accepted, it pushes `tok_data`. A single operand followed by an end marker yields that value with `res_malformed` low.
- R2: A token with kind 2'b01 is an operator. When accepted with at least two entries on the stack, it replaces the top two entries with one result. With `tok_op` 2'b00 or 2'b11 the result is their sum, modulo 2^16.
- R3: `tok_op` 2'b10 yields the low 16 bits of the product of the two entries.
- R4: `tok_op` 2'b01 yields left minus right, modulo 2^16. The left operand is the entry pushed earlier (the second one popped), and the right operand is the top entry.
- R5: The token stream A, B, +, C, * yields (A+B)*C, and chained operators work on any stack depth up to full.
- R6: A token with kind 2'b10 or 2'b11 is an end marker. The cycle after it is accepted, `res_valid` is high for one cycle and `res_data` holds the stack top. After that the stack is empty.
- R7: `res_malformed` is high with the result exactly when the stack depth at the end marker is not one. With an empty stack, `res_data` is 0.
- R8: An operand arriving with 8 entries on the stack is not pushed and leaves the stack unchanged. It sets `err_overflow`, which stays high until reset.
- R9: An operator arriving with fewer than two entries leaves the stack unchanged. It sets `err_underflow`, which stays high until reset, and `tok_ready` does not drop.
- R10: After an operator is accepted with at least two entries, `tok_ready` is low for exactly the next three cycles and then high again. At all other times it is high.
- R11: After reset, `tok_ready` is high and `res_valid`, `err_overflow` and `err_underflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token offered |
| tok_ready | output | 1 | Token can be taken this cycle |
| tok_kind | input | 2 | 00 operand, 01 operator, 1x end of expression |
| tok_op | input | 2 | Operator: 00 add, 01 subtract, 10 multiply, 11 add |
| tok_data | input | 16 | Operand value |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Stack top at end of expression |
| res_malformed | output | 1 | Depth at end was not one |
| err_overflow | output | 1 | Sticky: push onto a full stack refused |
| err_underflow | output | 1 | Sticky: operator on fewer than two entries refused |

## Verification
The bench sweeps operand triples that include zero, one, the sign boundary and all-ones through sum, difference, product and the (A+B)*C pattern.

- Sum, difference and product: a design that swapped the operand order would return the negated difference. One that dropped the wrap would diverge at the all-ones and sign-boundary values.
- Deepest case: eight values are pushed and reduced by chained adds. A ninth push is then refused, which catches a write that corrupts the top entry or an off-by-one full test.
- Empty and single-entry operators, empty ends, two-entry ends and back-to-back expressions: these expose a stack that is not cleared, a missing malformed flag, or a ready line that stalls on a refused operator.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

  typedef enum logic [1:0] {
    TK_OPND = 2'b00,
    TK_OPER = 2'b01,
    TK_END  = 2'b10,
    TK_END2 = 2'b11
  } tok_kind_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MUL  = 2'b10,
    OP_ADDX = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_POP_R = 2'b01,
    S_POP_L = 2'b10,
    S_PUSH  = 2'b11
  } ctrl_state_e;

endpackage

// File: rtl/rpn_rst_sync.sv
module rpn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/rpn_stack.sv
module rpn_stack #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] top,
  output logic [DW-1:0]    depth,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [DW-1:0]    depth_q;
  logic [DW-1:0]    depth_nxt;
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    top_ptr;
  logic             do_push;

  assign full    = (depth_q == DW'(DEPTH));
  assign do_push = push && !full;
  assign wr_ptr  = AW'(depth_q);
  assign top_ptr = AW'(depth_q - DW'(1));

  always_comb begin
    depth_nxt = depth_q;
    if (clr) begin
      depth_nxt = '0;
    end else if (do_push) begin
      depth_nxt = depth_q + DW'(1);
    end else if (pop && (depth_q != '0)) begin
      depth_nxt = depth_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else begin
      depth_q <= depth_nxt;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wr_en;
    assign wr_en = do_push && !clr && (wr_ptr == AW'(i));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        mem[i] <= din;
      end
    end
  end

  assign top   = (depth_q != '0) ? mem[top_ptr] : '0;
  assign depth = depth_q;

  // R8: the controller never asks for a push the stack must refuse
  assert_push_not_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9: the controller never pops an empty stack
  assert_pop_not_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (depth_q != '0));

  // R2: depth moves by at most one entry per cycle unless cleared
  assert_depth_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((depth_q == $past(depth_q)) ||
              (depth_q == $past(depth_q) + DW'(1)) ||
              (depth_q == $past(depth_q) - DW'(1))));

  // R6: a clear empties the stack
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (depth_q == '0));

endmodule

// File: rtl/rpn_alu.sv
module rpn_alu
  import rpn_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit HAS_SUB = 1'b1
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] prod;

  assign sum  = lhs + rhs;
  assign prod = lhs * rhs;

  if (HAS_SUB) begin : g_sub
    assign diff = lhs - rhs;
  end else begin : g_nosub
    assign diff = sum;
  end

  always_comb begin
    unique case (op)
      OP_SUB:  y = diff;
      OP_MUL:  y = prod;
      default: y = sum;
    endcase
  end

endmodule

// File: rtl/rpn_ctrl.sv
module rpn_ctrl
  import rpn_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  output logic             tok_ready,
  input  logic [1:0]       tok_kind,
  input  logic [1:0]       tok_op,
  input  logic [WIDTH-1:0] tok_data,
  input  logic [WIDTH-1:0] stk_top,
  input  logic [DW-1:0]    stk_depth,
  input  logic             stk_full,
  output logic             stk_push,
  output logic             stk_pop,
  output logic             stk_clr,
  output logic [WIDTH-1:0] stk_din,
  output alu_op_e          alu_op,
  output logic [WIDTH-1:0] alu_lhs,
  output logic [WIDTH-1:0] alu_rhs,
  input  logic [WIDTH-1:0] alu_y,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_data,
  output logic             res_malformed,
  output logic             err_overflow,
  output logic             err_underflow
);

  ctrl_state_e      state_q, state_nxt;
  alu_op_e          op_q;
  logic [WIDTH-1:0] rhs_q, lhs_q;
  logic             accept, is_opnd, is_oper, is_end;
  logic             short_stack, start_op, ovf_hit, udf_hit;
  logic             ovf_q, udf_q, rvalid_q, rmal_q;
  logic [WIDTH-1:0] rdata_q;

  assign tok_ready   = (state_q == S_IDLE);
  assign accept      = tok_valid && tok_ready;
  assign is_opnd     = (tok_kind == TK_OPND);
  assign is_oper     = (tok_kind == TK_OPER);
  assign is_end      = !is_opnd && !is_oper;
  assign short_stack = (stk_depth < DW'(2));
  assign start_op    = accept && is_oper && !short_stack;
  assign ovf_hit     = accept && is_opnd && stk_full;
  assign udf_hit     = accept && is_oper && short_stack;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      S_IDLE:  if (start_op) state_nxt = S_POP_R;
      S_POP_R: state_nxt = S_POP_L;
      S_POP_L: state_nxt = S_PUSH;
      S_PUSH:  state_nxt = S_IDLE;
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_nxt;
    end
  end

  always_comb begin
    stk_push = (accept && is_opnd && !stk_full) || (state_q == S_PUSH);
    stk_pop  = (state_q == S_POP_R) || (state_q == S_POP_L);
    stk_clr  = accept && is_end;
    stk_din  = (state_q == S_PUSH) ? alu_y : tok_data;
  end

  always_ff @(posedge clk) begin
    if (start_op) begin
      op_q <= alu_op_e'(tok_op);
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_POP_R) begin
      rhs_q <= stk_top;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_POP_L) begin
      lhs_q <= stk_top;
    end
  end

  assign alu_op  = op_q;
  assign alu_lhs = lhs_q;
  assign alu_rhs = rhs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (ovf_hit) ovf_q <= 1'b1;
      if (udf_hit) udf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= stk_clr;
    end
  end

  always_ff @(posedge clk) begin
    if (stk_clr) begin
      rdata_q <= stk_top;
      rmal_q  <= (stk_depth != DW'(1));
    end
  end

  assign res_valid     = rvalid_q;
  assign res_data      = rdata_q;
  assign res_malformed = rmal_q;
  assign err_overflow  = ovf_q;
  assign err_underflow = udf_q;

  // R10: a started operator blocks the input on the following cycle
  assert_busy_after_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_op |=> !tok_ready);

  // R10: the busy window ends with ready again three cycles on
  assert_ready_returns_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push && !tok_ready) |=> tok_ready);

  // R6: an accepted end marker produces a result strobe
  assert_end_gives_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_end) |=> res_valid);

  // R8: overflow flag is sticky
  assert_no_overflow_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);

  // R9: underflow flag is sticky and a refused operator keeps ready high
  assert_no_underflow_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);

  assert_udf_keeps_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    udf_hit |=> (tok_ready && !stk_pop));

endmodule

// File: rtl/rpn_eval.sv
module rpn_eval
  import rpn_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int DEPTH   = 8,
  parameter bit HAS_SUB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  output logic             tok_ready,
  input  logic [1:0]       tok_kind,
  input  logic [1:0]       tok_op,
  input  logic [WIDTH-1:0] tok_data,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_data,
  output logic             res_malformed,
  output logic             err_overflow,
  output logic             err_underflow
);

  localparam int DW = $clog2(DEPTH + 1);

  logic             rst_n_s;
  logic             push, pop, clr, full;
  logic [WIDTH-1:0] din, top;
  logic [DW-1:0]    depth;
  alu_op_e          aop;
  logic [WIDTH-1:0] lhs, rhs, y;

  rpn_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rpn_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n_s),
    .push  (push),
    .pop   (pop),
    .clr   (clr),
    .din   (din),
    .top   (top),
    .depth (depth),
    .full  (full)
  );

  rpn_alu #(.WIDTH(WIDTH), .HAS_SUB(HAS_SUB)) u_alu (
    .op  (aop),
    .lhs (lhs),
    .rhs (rhs),
    .y   (y)
  );

  rpn_ctrl #(.WIDTH(WIDTH), .DW(DW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .tok_valid     (tok_valid),
    .tok_ready     (tok_ready),
    .tok_kind      (tok_kind),
    .tok_op        (tok_op),
    .tok_data      (tok_data),
    .stk_top       (top),
    .stk_depth     (depth),
    .stk_full      (full),
    .stk_push      (push),
    .stk_pop       (pop),
    .stk_clr       (clr),
    .stk_din       (din),
    .alu_op        (aop),
    .alu_lhs       (lhs),
    .alu_rhs       (rhs),
    .alu_y         (y),
    .res_valid     (res_valid),
    .res_data      (res_data),
    .res_malformed (res_malformed),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
  );

endmodule

// File: tb/rpn_eval_tb.sv
`timescale 1ns/1ps
module rpn_eval_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tok_valid = 1'b0;
  logic        tok_ready;
  logic [1:0]  tok_kind = 2'b00;
  logic [1:0]  tok_op = 2'b00;
  logic [15:0] tok_data = 16'h0;
  logic        res_valid;
  logic [15:0] res_data;
  logic        res_malformed;
  logic        err_overflow;
  logic        err_underflow;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  rpn_eval u_dut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_kind(tok_kind), .tok_op(tok_op), .tok_data(tok_data),
    .res_valid(res_valid), .res_data(res_data), .res_malformed(res_malformed),
    .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tok_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] k, input logic [1:0] o, input logic [15:0] d);
    @(negedge clk);
    tok_valid = 1'b1;
    tok_kind = k;
    tok_op = o;
    tok_data = d;
    while (!tok_ready) @(negedge clk);
    @(posedge clk);
    #1 tok_valid = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    send(2'b00, 2'b00, d);
  endtask

  // R10: operator with two or more entries: ready low for three cycles
  task automatic oper(input logic [1:0] o);
    send(2'b01, o, 16'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 ready low in busy window", {31'd0, tok_ready}, 32'd0);
    end
    @(negedge clk);
    check("R10 ready back high", {31'd0, tok_ready}, 32'd1);
  endtask

  // R6 / R7: end marker, result next cycle, one-cycle strobe
  task automatic finish(input string tag, input logic [15:0] exp_d, input logic exp_m);
    send(2'b10, 2'b00, 16'h0);
    @(negedge clk);
    check({tag, " R6 res_valid"}, {31'd0, res_valid}, 32'd1);
    check({tag, " res_data"}, {16'd0, res_data}, {16'd0, exp_d});
    check({tag, " R7 malformed"}, {31'd0, res_malformed}, {31'd0, exp_m});
    @(negedge clk);
    check({tag, " R6 strobe one cycle"}, {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] vals [6];
    logic [15:0] acc;
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0003;
    vals[3] = 16'h7fff; vals[4] = 16'h8000; vals[5] = 16'hffff;

    do_reset();
    @(negedge clk);
    check("R11 ready after reset", {31'd0, tok_ready}, 32'd1);
    check("R11 res_valid after reset", {31'd0, res_valid}, 32'd0);
    check("R11 overflow after reset", {31'd0, err_overflow}, 32'd0);
    check("R11 underflow after reset", {31'd0, err_underflow}, 32'd0);

    // R1: single operands
    for (int i = 0; i < 6; i++) begin
      push(vals[i]);
      finish("R1 single operand", vals[i], 1'b0);
    end

    // R2 R3 R4: pairwise operators
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        push(vals[i]); push(vals[j]); oper(2'b00);
        finish("R2 add", vals[i] + vals[j], 1'b0);
        push(vals[i]); push(vals[j]); oper(2'b11);
        finish("R2 add alt code", vals[i] + vals[j], 1'b0);
        push(vals[i]); push(vals[j]); oper(2'b10);
        finish("R3 mul", 16'(vals[i] * vals[j]), 1'b0);
        push(vals[i]); push(vals[j]); oper(2'b01);
        finish("R4 sub", vals[i] - vals[j], 1'b0);
      end
    end

    // R5: A B + C *
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        for (int k = 0; k < 6; k++) begin
          push(vals[i]); push(vals[j]); oper(2'b00); push(vals[k]); oper(2'b10);
          finish("R5 (A+B)*C", 16'((vals[i] + vals[j]) * vals[k]), 1'b0);
        end
      end
    end

    // R5: A B C - * (deeper operands stay intact)
    push(16'd7); push(16'd10); push(16'd4); oper(2'b01); oper(2'b10);
    finish("R5 A*(B-C)", 16'd42, 1'b0);

    // R5: full depth then chained adds
    acc = 16'h0;
    for (int i = 0; i < 8; i++) begin
      push(16'(i * 16'h1111 + 3));
      acc = acc + 16'(i * 16'h1111 + 3);
    end
    check("R8 no overflow at exactly full", {31'd0, err_overflow}, 32'd0);
    for (int i = 0; i < 7; i++) oper(2'b00);
    finish("R5 deep sum", acc, 1'b0);

    // R7: empty and two-entry end markers
    finish("R7 empty end", 16'h0000, 1'b1);
    push(16'h00aa); push(16'h00bb);
    finish("R7 two entries", 16'h00bb, 1'b1);
    // R6: stack emptied by previous end
    push(16'h0009);
    finish("R6 fresh after end", 16'h0009, 1'b0);

    // R8: ninth push refused, contents unchanged
    acc = 16'h0;
    for (int i = 0; i < 8; i++) begin
      push(16'(i + 1));
      acc = acc + 16'(i + 1);
    end
    push(16'h5555);
    @(negedge clk);
    check("R8 overflow set", {31'd0, err_overflow}, 32'd1);
    for (int i = 0; i < 7; i++) oper(2'b00);
    finish("R8 stack unchanged", acc, 1'b0);
    check("R8 overflow sticky", {31'd0, err_overflow}, 32'd1);

    do_reset();
    check("R11 overflow cleared by reset", {31'd0, err_overflow}, 32'd0);

    // R9: operator on empty and on one entry
    send(2'b01, 2'b00, 16'h0);
    @(negedge clk);
    check("R9 underflow set", {31'd0, err_underflow}, 32'd1);
    check("R9 ready stays high", {31'd0, tok_ready}, 32'd1);
    push(16'h0005);
    send(2'b01, 2'b10, 16'h0);
    @(negedge clk);
    check("R9 ready stays high one entry", {31'd0, tok_ready}, 32'd1);
    finish("R9 stack unchanged", 16'h0005, 1'b0);
    check("R9 underflow sticky", {31'd0, err_underflow}, 32'd1);
    check("R9 overflow untouched", {31'd0, err_overflow}, 32'd0);

    // R6: end with kind 2'b11
    push(16'h0321);
    send(2'b11, 2'b00, 16'h0);
    @(negedge clk);
    check("R6 kind 11 end strobe", {31'd0, res_valid}, 32'd1);
    check("R6 kind 11 end data", {16'd0, res_data}, 32'h0321);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule